// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial bus placed in front of a 2048 x 8 memory. It runs on a fast system clock and oversamples the bus clock and data lines. It detects start and stop conditions and shifts bytes in and out. It answers on the data line only through an open-drain pull-down enable.

The first byte after a start carries a fixed four-bit tag, three high word-address bits and a direction bit. A write transfer loads the full 11-bit word pointer from those three bits and the next byte. Every following byte goes out as a one-cycle write beat to a separate page-write controller. A read transfer streams bytes from the current pointer through a synchronous read port. The read port returns data one system clock after the address.

The pointer keeps its value between transfers. That gives current-address reads, random reads (an address-only write, a repeated start, then a read) and sequential reads. While the page-write controller reports busy, the engine stays silent.

Top module: `tw_mem_slave`

## Requirements
- R1: Both lines pass through two-flop synchronizers. A falling SDA edge while SCL is high is a start and makes the next byte a device byte. A rising SDA edge while SCL is high is a stop and returns the engine to idle. After a stop, the pointer value stays available to the next read.
- R2: A device byte is accepted only when its bits 7..4 equal binary 1010. For any other value the engine acknowledges nothing and ignores all bytes until the next start.
- R3: Each accepted byte is acknowledged. SDA is pulled low from just after the eighth SCL falling edge of the byte until just after the ninth. The pull-down enable only changes while the synchronized SCL is low.
- R4: In a write transfer the second byte sets pointer = {device bits 3..1, byte}. Every later byte is acknowledged and issued as a one-cycle wr_valid_o pulse, with wr_addr_o set to the pointer and wr_data_o set to the byte.
- R5: After each write beat only pointer bits 3..0 increment, wrapping within the 16-byte page; bits 10..4 stay unchanged.
- R6: A read transfer (device bit 0 = 1) starts at the current pointer and ignores device bits 3..1. The pointer starts at 0 after reset.
- R7: Read bytes go out MSB first, each bit changed after an SCL falling edge. After each byte the pointer increments over the whole array, wrapping from 2047 to 0.
- R8: A master acknowledge (SDA low in the ninth clock) makes the engine send the next byte. A master NACK makes it release SDA and ignore the bus until the next start.
- R9: While wr_busy_i is high when a device byte completes, that byte is not acknowledged.
- R10: A start or stop in the middle of a byte aborts the transfer and issues no write beat for the partial byte.
- R11: During and after reset, sda_oe_o and wr_valid_o are low and rd_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_busy_i | input | 1 | Page-write controller is in its internal write cycle |
| wr_valid_o | output | 1 | One-cycle write beat strobe |
| wr_addr_o | output | 11 | Word address of the write beat |
| wr_data_o | output | 8 | Data of the write beat |
| rd_addr_o | output | 11 | Read port address (current pointer) |
| rd_data_i | input | 8 | Read port data, valid one clock after rd_addr_o |

## Verification
The assertions take for granted that SCL edges are many system clocks apart, so a rise and a fall of the synchronized clock never land on adjacent cycles. They also assume the master changes SDA only while SCL is low, except for deliberate start and stop edges. The stimulus holds each SCL half period for six or more system clocks, and it moves SDA only in the middle of a low phase. Starts and stops are built with SCL held high for eight clocks on each side of the data edge. The bench drives wr_busy_i only between transfers.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int TW_AW        = 11;
    localparam int TW_DW        = 8;
    localparam int TW_PAGE_BITS = 4;
    localparam int TW_SYNC      = 2;
    localparam logic [3:0] TW_DEV_TAG = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DACK,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_RLD
    } tw_state_t;

    typedef struct packed {
        logic [3:0] tag;
        logic [2:0] hi;
        logic       rd;
    } tw_devb_t;

    function automatic logic tw_dev_match(input tw_devb_t d);
        return d.tag == TW_DEV_TAG;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = tw_pkg::TW_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_o      = scl_sh[STAGES-1];
    assign sda_o      = sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_q;
    assign scl_fall_o = ~scl_o & scl_q;
    assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/tw_word_ptr.sv
module tw_word_ptr #(
    parameter int AW        = tw_pkg::TW_AW,
    parameter int PAGE_BITS = tw_pkg::TW_PAGE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          rd_step_i,
    input  logic          wr_step_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] TOP = '1;

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load_i)
            ptr_q <= load_val_i;
        else if (rd_step_i)
            ptr_q <= ptr_q + 1'b1;
        else if (wr_step_i)
            ptr_q <= {ptr_q[AW-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + 1'b1};
    end

    assign ptr_o = ptr_q;

    AST_READ_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rd_step_i && !load_i && ptr_q == TOP) |=> (ptr_q == '0)); // R7

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_step_i && !load_i && !rd_step_i) |=>
        (ptr_q[AW-1:PAGE_BITS] == $past(ptr_q[AW-1:PAGE_BITS]))); // R5

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int AW        = TW_AW,
    parameter int DW        = TW_DW,
    parameter int PAGE_BITS = TW_PAGE_BITS,
    parameter int SYNC      = TW_SYNC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic          wr_busy_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i
);
    localparam int HI_W = AW - DW;
    localparam int BC_W = $clog2(DW + 1);
    localparam logic [BC_W-1:0] BYTE_END = BC_W'(DW);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    tw_line_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    tw_state_t        st;
    logic [BC_W-1:0]  bitc;
    logic [DW-1:0]    rx, tx;
    logic [HI_W-1:0]  hi_q;
    logic             rd_q, oe_q;
    logic             wv_q;
    logic [AW-1:0]    wa_q, ptr;
    logic [DW-1:0]    wd_q;
    logic             byte_fall, ptr_load, ptr_rd, ptr_wr;
    tw_devb_t         devb;

    assign byte_fall = scl_fall && (bitc == BYTE_END) && !bus_start && !bus_stop;
    assign ptr_load  = byte_fall && (st == ST_ADDR);
    assign ptr_rd    = byte_fall && (st == ST_RDAT);
    assign ptr_wr    = byte_fall && (st == ST_WDAT);
    assign devb      = tw_devb_t'(rx);

    tw_word_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk(clk), .rst(rst),
        .load_i(ptr_load), .load_val_i({hi_q, rx}),
        .rd_step_i(ptr_rd), .wr_step_i(ptr_wr),
        .ptr_o(ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            bitc <= '0;
            rx   <= '0;
            tx   <= '0;
            hi_q <= '0;
            rd_q <= 1'b0;
            oe_q <= 1'b0;
            wv_q <= 1'b0;
            wa_q <= '0;
            wd_q <= '0;
        end else begin
            wv_q <= 1'b0;
            if (bus_start) begin
                st   <= ST_DEV;
                bitc <= '0;
                oe_q <= 1'b0;
            end else if (bus_stop) begin
                st   <= ST_IDLE;
                bitc <= '0;
                oe_q <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_ADDR, ST_WDAT: begin
                        if (scl_rise) begin
                            rx   <= {rx[DW-2:0], sda_s};
                            bitc <= bitc + 1'b1;
                        end
                        if (byte_fall) begin
                            bitc <= '0;
                            if (st == ST_DEV) begin
                                if (tw_dev_match(devb) && !wr_busy_i) begin
                                    oe_q <= 1'b1;
                                    hi_q <= devb.hi;
                                    rd_q <= devb.rd;
                                    st   <= ST_DACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_ADDR) begin
                                oe_q <= 1'b1;
                                st   <= ST_AACK;
                            end else begin
                                oe_q <= 1'b1;
                                wv_q <= 1'b1;
                                wa_q <= ptr;
                                wd_q <= rx;
                                st   <= ST_WACK;
                            end
                        end
                    end
                    ST_DACK: if (scl_fall) begin
                        if (rd_q) begin
                            tx   <= rd_data_i;
                            oe_q <= ~rd_data_i[DW-1];
                            st   <= ST_RDAT;
                        end else begin
                            oe_q <= 1'b0;
                            st   <= ST_ADDR;
                        end
                    end
                    ST_AACK, ST_WACK: if (scl_fall) begin
                        oe_q <= 1'b0;
                        st   <= ST_WDAT;
                    end
                    ST_RDAT: begin
                        if (scl_rise)
                            bitc <= bitc + 1'b1;
                        if (byte_fall) begin
                            oe_q <= 1'b0;
                            bitc <= '0;
                            st   <= ST_RACK;
                        end else if (scl_fall) begin
                            tx   <= {tx[DW-2:0], 1'b0};
                            oe_q <= ~tx[DW-2];
                        end
                    end
                    ST_RACK: if (scl_rise)
                        st <= sda_s ? ST_IDLE : ST_RLD;
                    ST_RLD: if (scl_fall) begin
                        tx   <= rd_data_i;
                        oe_q <= ~rd_data_i[DW-1];
                        st   <= ST_RDAT;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe_o   = oe_q;
    assign wr_valid_o = wv_q;
    assign wr_addr_o  = wa_q;
    assign wr_data_o  = wd_q;
    assign rd_addr_o  = ptr;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> !scl_s); // R3

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wv_q |=> !wv_q); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !oe_q); // R8

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && byte_fall && wr_busy_i) |=> (st == ST_IDLE && !oe_q)); // R9

    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |=> !wv_q); // R10

endmodule

// File: tb/tw_mem_slave_bench.sv
module tw_mem_slave_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic sda_oe, wr_valid;
    logic [10:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic sda_bus;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    tw_mem_slave u_tw_mem_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .wr_busy_i(busy),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    logic [7:0] mem [2048];
    int cap_n = 0;
    logic [10:0] cap_a [64];
    logic [7:0]  cap_d [64];
    int n_chk = 0, n_fail = 0;

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 37 + 11);
    endfunction

    initial for (int i = 0; i < 2048; i++) mem[i] = init_val(i);

    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (wr_valid) begin
            mem[wr_addr] <= wr_data;
            if (cap_n < 64) begin
                cap_a[cap_n] <= wr_addr;
                cap_d[cap_n] <= wr_data;
            end
            cap_n <= cap_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(6);
        scl_m = 1'b1; wt(8);
        sda_m = 1'b0; wt(8);
        scl_m = 1'b0; wt(6);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(6);
        scl_m = 1'b1; wt(8);
        sda_m = 1'b1; wt(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(6);
            scl_m = 1'b1; wt(8);
            scl_m = 1'b0; wt(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(6);
        scl_m = 1'b1; wt(4);
        ack = ~sda_bus; wt(4);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(6);
            scl_m = 1'b1; wt(4);
            b[i] = sda_bus; wt(4);
            scl_m = 1'b0;
        end
        wt(2);
        sda_m = ~give_ack; wt(6);
        scl_m = 1'b1; wt(8);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    // dev, addr, data, expected device ack
    localparam logic [24:0] VEC [5] = '{
        {8'hA0, 8'h10, 8'h55, 1'b1},
        {8'hA6, 8'h3F, 8'hAA, 1'b1},
        {8'hB0, 8'h00, 8'h00, 1'b0},
        {8'h20, 8'h00, 8'h00, 1'b0},
        {8'hAE, 8'hFF, 8'hC3, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        int c0;
        wt(5);
        chk("R11 sda_oe in reset", 32'(sda_oe), 0);
        rst = 1'b0;
        wt(3);
        chk("R11 sda_oe after reset", 32'(sda_oe), 0);
        chk("R11 wr_valid after reset", 32'(wr_valid), 0);
        chk("R11 pointer after reset", 32'(rd_addr), 0);

        for (int v = 0; v < 5; v++) begin
            logic [7:0] dv, ad, dt;
            logic ea;
            {dv, ad, dt, ea} = VEC[v];
            c0 = cap_n;
            bus_start();
            send_byte(dv, ack);
            chk("R2 device byte ack", 32'(ack), 32'(ea));
            if (ea) begin
                send_byte(ad, ack);
                chk("R4 address ack", 32'(ack), 1);
                send_byte(dt, ack);
                chk("R4 data ack", 32'(ack), 1);
                bus_stop();
                wt(4);
                chk("R4 one write beat", 32'(cap_n - c0), 1);
                chk("R4 write address", 32'(cap_a[c0]), 32'({dv[3:1], ad}));
                chk("R4 write data", 32'(cap_d[c0]), 32'(dt));
                bus_start();
                send_byte({dv[7:1], 1'b0}, ack);
                send_byte(ad, ack);
                bus_start();
                send_byte({dv[7:1], 1'b1}, ack);
                recv_byte(1'b0, b);
                bus_stop();
                chk("R6 random read back", 32'(b), 32'(dt));
            end else begin
                send_byte(8'h00, ack);
                chk("R2 later byte ignored", 32'(ack), 0);
                bus_stop();
                wt(4);
                chk("R2 no write beat", 32'(cap_n - c0), 0);
            end
        end

        // R5 page wrap on writes
        c0 = cap_n;
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h1E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        bus_stop();
        wt(4);
        chk("R5 beat count", 32'(cap_n - c0), 3);
        chk("R5 beat0 addr", 32'(cap_a[c0]), 32'h11E);
        chk("R5 beat1 addr", 32'(cap_a[c0+1]), 32'h11F);
        chk("R5 beat2 wraps in page", 32'(cap_a[c0+2]), 32'h110);

        // R7 sequential read wraps 2047 -> 0, R8 NACK ends read
        bus_start();
        send_byte(8'hAE, ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(8'hAF, ack);
        chk("R6 read device ack", 32'(ack), 1);
        recv_byte(1'b1, b);
        chk("R7 byte at 2047", 32'(b), 32'hC3);
        recv_byte(1'b0, b);
        chk("R7 wrapped to 0", 32'(b), 32'(init_val(0)));
        send_byte(8'hA0, ack);
        chk("R8 quiet after NACK", 32'(ack), 0);
        bus_stop();
        chk("R7 pointer after two bytes", 32'(rd_addr), 1);

        // R6 current read ignores device bits 3..1
        bus_start();
        send_byte(8'hA5, ack);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R6 current address read", 32'(b), 32'(init_val(1)));

        // R9 busy suppresses ack
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, ack);
        bus_stop();
        chk("R9 no ack while busy", 32'(ack), 0);
        busy = 1'b0;
        bus_start();
        send_byte(8'hA0, ack);
        bus_stop();
        chk("R9 ack once idle", 32'(ack), 1);

        // R10 start mid-byte aborts
        c0 = cap_n;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h40, ack);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R10 no beat after start abort", 32'(cap_n - c0), 0);
        chk("R10 read after abort", 32'(b), 32'(init_val(32'h40)));

        // R1 stop mid-byte returns to idle, pointer kept
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h50, ack);
        send_bits(8'hFF, 3);
        bus_stop();
        wt(4);
        chk("R10 no beat after stop abort", 32'(cap_n - c0), 0);
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R1 read after stop", 32'(b), 32'(init_val(32'h50)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule